// File: doc/BRIEF.md
# Multiply-Accumulate Instruction Extension Unit

This execution-stage unit attaches to a small 32-bit core and speeds up the inner loop of multi-precision product scanning. It holds a three-word accumulator. A mode flag, written through a control-register port, changes what the core's bitwise-test opcode does. While the flag is clear, the test opcode performs its normal AND-and-set-flags operation. While the flag is set, the same opcode forms the full double-width product of its two register operands and adds it into the accumulator in one clock cycle. The toolchain needs no change: software sets the flag when a field multiplication starts and clears it when the multiplication ends.

Two further decoded operations serve the product-scanning column loop. One returns a selected accumulator word as a register result. The other returns the lowest word and shifts the accumulator down by one word, with zeros filling the top word. The core's pipeline, register file and memory system lie outside the unit. The unit receives an already-decoded operation with its operand values and returns a result word, write strobes and test flags.

Top module: `mac_ext_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all accumulator words and the mode flag.
- R2: A control write (`ctl_we` high) loads `ctl_wdata` into the mode flag at the clock edge, and `mode_on` shows it from then on. An operation issued in the same cycle as the write still uses the old mode.
- R3: With the mode flag clear, the test operation (op code 1) raises `flags_we`. It drives `flag_n` with the top bit of `op_a & op_b`, drives `flag_z` high exactly when `op_a & op_b` is zero, keeps `res_we` low and leaves the accumulator unchanged.
- R4: With the mode flag set, op code 1 adds the full 2·DATA_W-bit product `op_a * op_b`, zero-extended, to the accumulator at the next clock edge.
- R5: A carry out of the lower two words propagates into the top word. A sum beyond the accumulator width wraps modulo 2^(3·DATA_W).
- R6: With the mode flag set, op code 1 keeps `flags_we` and `res_we` low.
- R7: The read operation (op code 2) drives `res_we` high and `res_data` with accumulator word `rd_sel` (0 lowest, 2 highest). A `rd_sel` value of 3 returns zero. The accumulator is unchanged, in either mode.
- R8: The shift operation (op code 3) drives `res_we` high and returns the old lowest word. At the next edge it moves the accumulator down by one word and zero-fills the top word, in either mode.
- R9: With `op_valid` low, or with op code 0, `res_we` and `flags_we` stay low and the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded operation is present this cycle |
| op_code | input | 2 | 0 none, 1 test / multiply-accumulate, 2 read word, 3 shift |
| op_a | input | DATA_W | First register operand |
| op_b | input | DATA_W | Second register operand |
| rd_sel | input | SEL_W | Accumulator word index for the read operation |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 1 | New value of the mode flag |
| res_data | output | DATA_W | Result word for register write-back |
| res_we | output | 1 | Result word is valid for write-back |
| flags_we | output | 1 | Test flags are valid for update |
| flag_n | output | 1 | Negative flag of the test |
| flag_z | output | 1 | Zero flag of the test |
| mode_on | output | 1 | Current multiply-accumulate mode flag |

## Verification
On every cycle the assertions check the following:
- the accumulator steps: the sum after a multiply-accumulate, the zero-filled top word after a shift, and a held value otherwise;
- the mode flag loading on a control write and holding without one;
- the absence of flag updates in multiply-accumulate mode;
- the quiet outputs when no operation is issued.

Only the bench's scenarios can show the rest:
- the flag values over swept operand pairs;
- the sums accumulated across long operand sweeps, read back word by word;
- the wrap past the full accumulator width;
- the same-cycle ordering of a mode write against a test operation.

// File: rtl/mac_ext_pkg.sv
package mac_ext_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TST  = 2'd1,
    OP_RD   = 2'd2,
    OP_SHR  = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic mac;
    logic tst;
    logic rd;
    logic shr;
  } mac_strobe_t;

endpackage

// File: rtl/mac_ext_decode.sv
module mac_ext_decode
  import mac_ext_pkg::*;
(
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic        mode_on,
  output mac_strobe_t st
);

  always_comb begin
    st = '0;
    if (op_valid) begin
      unique case (mac_op_e'(op_code))
        OP_TST:  begin
          st.mac = mode_on;
          st.tst = !mode_on;
        end
        OP_RD:   st.rd  = 1'b1;
        OP_SHR:  st.shr = 1'b1;
        default: st     = '0;
      endcase
    end
  end

endmodule

// File: rtl/mac_ext_flags.sv
module mac_ext_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              neg,
  output logic              zero
);

  function automatic logic [1:0] test_flags(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] m;
    m = x & y;
    return {m[DATA_W-1], (m == '0)};
  endfunction

  logic [1:0] nz;
  assign nz   = test_flags(a, b);
  assign neg  = nz[1];
  assign zero = nz[0];

endmodule

// File: rtl/mac_ext_acc.sv
module mac_ext_acc #(
  parameter int DATA_W    = 32,
  parameter int ACC_WORDS = 3,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mac_en,
  input  logic              shr_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] low_word
);

  localparam int ACC_W  = ACC_WORDS * DATA_W;
  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] mac_sum(input logic [ACC_W-1:0]  acc,
                                               input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    logic [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'(y);
    return acc + ACC_W'(p);
  endfunction

  function automatic logic [ACC_W-1:0] word_shift(input logic [ACC_W-1:0] acc);
    return {{DATA_W{1'b0}}, acc[ACC_W-1:DATA_W]};
  endfunction

  logic [ACC_W-1:0] acc_flat;
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    acc_next = acc_flat;
    if (mac_en)      acc_next = mac_sum(acc_flat, a, b);
    else if (shr_en) acc_next = word_shift(acc_flat);
  end

  for (genvar w = 0; w < ACC_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= acc_next[w*DATA_W +: DATA_W];
    end
    assign acc_flat[w*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < ACC_WORDS; i++)
      if (rd_sel == SEL_W'(i)) rd_word = acc_flat[i*DATA_W +: DATA_W];
  end

  assign low_word = acc_flat[DATA_W-1:0];

  AST_ACC_RESET: assert property (@(posedge clk)
    $past(rst) |-> acc_flat == '0);  // R1

  AST_MAC_SUM: assert property (@(posedge clk) disable iff (rst)
    mac_en |=> acc_flat == $past(acc_flat) + ACC_W'($past(a) * $past(b)));  // R4

  AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    shr_en && !mac_en |=> acc_flat[ACC_W-1 -: DATA_W] == '0);  // R8

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mac_en && !shr_en |=> $stable(acc_flat));  // R9

endmodule

// File: rtl/mac_ext_unit.sv
module mac_ext_unit
  import mac_ext_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_WORDS = 3,
  parameter int SEL_W     = (ACC_WORDS > 2) ? $clog2(ACC_WORDS + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              ctl_we,
  input  logic              ctl_wdata,
  output logic [DATA_W-1:0] res_data,
  output logic              res_we,
  output logic              flags_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              mode_on
);

  logic              mode_q;
  mac_strobe_t       st;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] low_word;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= 1'b0;
    else if (ctl_we) mode_q <= ctl_wdata;
  end
  assign mode_on = mode_q;

  mac_ext_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .mode_on  (mode_q),
    .st       (st)
  );

  mac_ext_flags #(.DATA_W(DATA_W)) u_flags (
    .a    (op_a),
    .b    (op_b),
    .neg  (flag_n),
    .zero (flag_z)
  );

  mac_ext_acc #(.DATA_W(DATA_W), .ACC_WORDS(ACC_WORDS), .SEL_W(SEL_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .mac_en   (st.mac),
    .shr_en   (st.shr),
    .a        (op_a),
    .b        (op_b),
    .rd_sel   (rd_sel),
    .rd_word  (rd_word),
    .low_word (low_word)
  );

  always_comb begin
    res_data = '0;
    if (st.rd)       res_data = rd_word;
    else if (st.shr) res_data = low_word;
  end
  assign res_we   = st.rd | st.shr;
  assign flags_we = st.tst;

  AST_MODE_RESET: assert property (@(posedge clk)
    $past(rst) |-> !mode_on);  // R1

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> mode_on == $past(ctl_wdata));  // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(mode_on));  // R2

  AST_MAC_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == 2'd1 && mode_on |-> !flags_we && !res_we);  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !flags_we && !res_we);  // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.mac, st.tst, st.rd, st.shr}));  // R9

endmodule

// File: tb/mac_ext_unit_test.sv
`timescale 1ns/1ps
module mac_ext_unit_test;

  localparam int DW = 8;
  localparam int AW = 3 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'd0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic [1:0]    rd_sel = 2'd0;
  logic          ctl_we = 1'b0;
  logic          ctl_wdata = 1'b0;
  logic [DW-1:0] res_data;
  logic          res_we, flags_we, flag_n, flag_z, mode_on;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [AW-1:0] m = '0;

  logic [DW-1:0] s_res;
  logic          s_rwe, s_fwe, s_n, s_z;

  always #2.5 clk = ~clk;

  mac_ext_unit #(.DATA_W(DW), .ACC_WORDS(3)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .rd_sel(rd_sel), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .res_data(res_data), .res_we(res_we),
    .flags_we(flags_we), .flag_n(flag_n), .flag_z(flag_z), .mode_on(mode_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] c, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [1:0] sel,
                      input bit cwe, input bit cwd);
    @(negedge clk);
    op_valid = v; op_code = c; op_a = a; op_b = b; rd_sel = sel;
    ctl_we = cwe; ctl_wdata = cwd;
    #1;
    s_res = res_data; s_rwe = res_we; s_fwe = flags_we; s_n = flag_n; s_z = flag_z;
    @(posedge clk);
    #0.5;
    op_valid = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic read_acc(input string req);
    for (int w = 0; w < 3; w++) begin
      step(1, 2'd2, 8'h00, 8'h00, w[1:0], 0, 0);
      chk(req, {24'h0, s_res}, {24'h0, m[w*DW +: DW]});
      chk(req, {31'h0, s_rwe}, 32'h1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    // R1: reset state
    chk("R1", {31'h0, mode_on}, 32'h0);
    m = '0;
    read_acc("R1");

    // R3: test mode flags over a sweep
    for (int a = 0; a < 256; a++) begin
      logic [DW-1:0] b, an;
      b  = DW'((a * 37 + 11) & 255);
      an = DW'(a) & b;
      step(1, 2'd1, DW'(a), b, 2'd0, 0, 0);
      if (s_fwe !== 1'b1 || s_n !== an[DW-1] || s_z !== (an == 0) || s_rwe !== 1'b0)
        chk("R3", {28'h0, s_fwe, s_n, s_z, s_rwe}, {28'h0, 1'b1, an[DW-1], an == 0, 1'b0});
      else tests++;
    end
    read_acc("R3");

    // R2: same-cycle mode write uses old mode
    step(1, 2'd1, 8'h03, 8'h05, 2'd0, 1, 1);
    chk("R2", {31'h0, s_fwe}, 32'h1);
    chk("R2", {31'h0, mode_on}, 32'h1);
    read_acc("R2");

    // R4/R6: accumulate sweep
    for (int a = 0; a < 256; a++) begin
      logic [DW-1:0] bl [4];
      bl[0] = 8'hff; bl[1] = 8'h01; bl[2] = DW'(a) ^ 8'h5a; bl[3] = 8'h80;
      for (int k = 0; k < 4; k++) begin
        step(1, 2'd1, DW'(a), bl[k], 2'd0, 0, 0);
        m = m + AW'(a * bl[k]);
        if (s_fwe !== 1'b0 || s_rwe !== 1'b0)
          chk("R6", {30'h0, s_fwe, s_rwe}, 32'h0);
      end
      if (a % 32 == 31) read_acc("R4");
    end
    chk("R6", {31'h0, s_fwe}, 32'h0);

    // R5: carry into top word and wrap beyond 24 bits
    for (int k = 0; k < 300; k++) begin
      step(1, 2'd1, 8'hff, 8'hff, 2'd0, 0, 0);
      m = m + AW'(255 * 255);
    end
    read_acc("R5");

    // R7: select 3 returns zero with nonzero accumulator
    step(1, 2'd2, 8'h00, 8'h00, 2'd3, 0, 0);
    chk("R7", {23'h0, s_rwe, s_res}, {23'h0, 1'b1, 8'h00});

    // R8: shift down three times
    for (int k = 0; k < 3; k++) begin
      step(1, 2'd3, 8'h00, 8'h00, 2'd0, 0, 0);
      chk("R8", {23'h0, s_rwe, s_res}, {23'h0, 1'b1, m[DW-1:0]});
      m = m >> DW;
      read_acc("R8");
    end

    // R9: idle and none-op with operands present
    step(1, 2'd1, 8'h12, 8'h34, 2'd0, 0, 0);
    m = m + AW'(8'h12 * 8'h34);
    step(0, 2'd1, 8'hff, 8'hff, 2'd0, 0, 0);
    chk("R9", {30'h0, s_rwe, s_fwe}, 32'h0);
    step(1, 2'd0, 8'hff, 8'hff, 2'd2, 0, 0);
    chk("R9", {30'h0, s_rwe, s_fwe}, 32'h0);
    read_acc("R9");

    // R2: clear mode, test behaves normally, acc unchanged
    step(0, 2'd0, 8'h00, 8'h00, 2'd0, 1, 0);
    chk("R2", {31'h0, mode_on}, 32'h0);
    step(1, 2'd1, 8'h80, 8'hc0, 2'd0, 0, 0);
    chk("R3", {29'h0, s_fwe, s_n, s_z}, {29'h0, 3'b110});
    step(1, 2'd3, 8'h00, 8'h00, 2'd0, 0, 0);
    chk("R8", {24'h0, s_res}, {24'h0, m[DW-1:0]});
    m = m >> DW;
    read_acc("R8");

    // R1: mid-run reset
    step(1, 2'd0, 8'h00, 8'h00, 2'd0, 1, 1);
    step(1, 2'd1, 8'hab, 8'hcd, 2'd0, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m = '0;
    chk("R1", {31'h0, mode_on}, 32'h0);
    read_acc("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule